// File: doc/BRIEF.md
# Clock-Generator Control Register Slave (Two-Wire Serial)

This block is a serial-bus target that owns six 8-bit control registers for a system clock generator. A bus master writes them using a fixed block-write sequence: the device address with the write bit, then two mandatory header bytes that are acknowledged and thrown away, then data bytes. The data bytes always fill the registers from register 0 upward, one register per byte. There is no register pointer that the master can set. A STOP may end the transfer after any whole byte, and every register written before that point keeps its new value.

On a read, the slave first returns a byte count and then registers 0, 1, 2 and onward, until the master answers with a not-acknowledge. SCL and SDA are sampled by a faster system clock after a two-flop synchroniser. The slave never drives SDA high. It only pulls SDA low, through `sdaDriveLow`, and the pad is meant to implement that as an open-drain driver. The current register contents are presented in parallel on `regBus` for use by the clock logic.

Top module: `clkctl_i2c_slave`

## Requirements
- R1: Only the address byte 0xD2 (write) or 0xD3 (read), which is 7-bit address 0x69 with bit 0 as the read flag, is acknowledged. Any other address receives no acknowledge, and the slave ignores the bus until the next START.
- R2: After a write address, the first two bytes are acknowledged and their contents are discarded.
- R3: The write data bytes after those two go to register 0, then register 1, and so on upward, one register per byte.
- R4: A STOP after any complete data byte leaves every register written so far with its new value, and leaves the other registers unchanged.
- R5: After a read address, the slave transmits a byte count and then register 0, register 1 and onward. It stops transmitting when the master does not acknowledge a byte.
- R6: After reset, register 0 holds 0x00 and registers 1 to 5 hold 0xFF. `regBus[8*i+7:8*i]` carries register i.
- R7: Every byte of an addressed write is acknowledged, including bytes beyond register 5.
- R8: The byte count returned first on a read equals 6, the number of registers.
- R9: Write bytes beyond register 5 are dropped. Read bytes beyond register 5 return 0xFF.
- R10: A STOP or a repeated START in the middle of a byte abandons that byte without changing any register. After a repeated START, the byte that follows is decoded as an address.
- R11: SDA is pulled low only in acknowledge slots and for 0 bits that the slave transmits. A new pull-low begins only while SCL is low.
- R12: START and STOP are recognised only as SDA edges while SCL is high. SDA edges while SCL is low never start a transfer.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, much faster than SCL |
| rstN | input | 1 | Active-low asynchronous reset |
| sclIn | input | 1 | Serial clock as seen on the bus |
| sdaIn | input | 1 | Serial data as seen on the bus |
| sdaDriveLow | output | 1 | 1 pulls SDA low; 0 releases it |
| regBus | output | 48 | Register file, register i in bits 8*i+7 to 8*i |

## Verification
Some properties are checked by assertions on every cycle. A STOP always returns the control to idle. A pull-low on SDA never begins while SCL is high. No register changes unless a complete data byte is committed. A commit beyond the last register leaves the file untouched, and a commit to register 0 stores exactly the byte that was shifted in.

Other behaviour can only be shown by the bench's bus scenarios, which act as the master. These cover the address filtering, the discarded header bytes, the read sequence with its leading count and 0xFF fill, and the abandoned transfers under a mid-byte STOP and a mid-byte repeated START.

// File: rtl/clkctl_pkg.sv
package clkctl_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_RX,
    ST_ACKOUT,
    ST_TX,
    ST_ACKIN
  } busState_t;

  typedef enum logic [1:0] {
    PH_ADDR,
    PH_CMD,
    PH_CNT,
    PH_DATA
  } wrPhase_t;

  // strobes from control to datapath, each valid for one clk cycle
  typedef struct packed {
    logic rxShift;     // shift sampled SDA into receive byte
    logic idxClear;    // reset the register pointer
    logic wrCommit;    // store received byte at pointer, advance
    logic txLoad;      // load next transmit byte
    logic txSelCount;  // with txLoad: load the byte count instead
    logic txShift;     // advance transmit byte by one bit
  } dpStrobe_t;

endpackage

// File: rtl/clkctl_busfront.sv
module clkctl_busfront #(
  parameter int SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rstN,
  input  logic sclIn,
  input  logic sdaIn,
  output logic sclS,
  output logic sdaS,
  output logic sclRise,
  output logic sclFall,
  output logic startDet,
  output logic stopDet
);

  logic [SYNC_STAGES-1:0] sclChain;
  logic [SYNC_STAGES-1:0] sdaChain;
  logic sclPrev;
  logic sdaPrev;

  generate
    if (SYNC_STAGES == 1) begin : g_single
      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN) begin
          sclChain <= '1;
          sdaChain <= '1;
        end else begin
          sclChain <= sclIn;
          sdaChain <= sdaIn;
        end
      end
    end else begin : g_chain
      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN) begin
          sclChain <= '1;
          sdaChain <= '1;
        end else begin
          sclChain <= {sclChain[SYNC_STAGES-2:0], sclIn};
          sdaChain <= {sdaChain[SYNC_STAGES-2:0], sdaIn};
        end
      end
    end
  endgenerate

  assign sclS = sclChain[SYNC_STAGES-1];
  assign sdaS = sdaChain[SYNC_STAGES-1];

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      sclPrev <= 1'b1;
      sdaPrev <= 1'b1;
    end else begin
      sclPrev <= sclS;
      sdaPrev <= sdaS;
    end
  end

  assign sclRise  = sclS & ~sclPrev;
  assign sclFall  = ~sclS & sclPrev;
  assign startDet = sclS & sclPrev & sdaPrev & ~sdaS;
  assign stopDet  = sclS & sclPrev & ~sdaPrev & sdaS;

endmodule

// File: rtl/clkctl_ctrl.sv
module clkctl_ctrl
  import clkctl_pkg::*;
#(
  parameter logic [6:0] DEV_ADDR = 7'h69
) (
  input  logic      clk,
  input  logic      rstN,
  input  logic      sclS,
  input  logic      sdaS,
  input  logic      sclRise,
  input  logic      sclFall,
  input  logic      startDet,
  input  logic      stopDet,
  input  logic [7:0] rxByte,
  input  logic      txMsb,
  output dpStrobe_t strobe,
  output logic      sdaDriveLow
);

  localparam int BITS_PER_BYTE = 8;
  localparam int CNT_W = $clog2(BITS_PER_BYTE + 1);

  busState_t        state, stateNext;
  wrPhase_t         phase, phaseNext;
  logic [CNT_W-1:0] bitCnt, bitCntNext;
  logic             byteDone, byteDoneNext;
  logic             isRead, isReadNext;
  logic             firstTx, firstTxNext;

  always_comb begin
    stateNext    = state;
    phaseNext    = phase;
    bitCntNext   = bitCnt;
    byteDoneNext = byteDone;
    isReadNext   = isRead;
    firstTxNext  = firstTx;
    strobe       = '0;

    if (stopDet) begin
      stateNext = ST_IDLE;
    end else if (startDet) begin
      stateNext    = ST_RX;
      phaseNext    = PH_ADDR;
      bitCntNext   = '0;
      byteDoneNext = 1'b0;
    end else begin
      unique case (state)
        ST_IDLE: ;
        ST_RX: begin
          if (sclRise && !byteDone) begin
            strobe.rxShift = 1'b1;
            bitCntNext     = bitCnt + 1'b1;
            if (bitCnt == CNT_W'(BITS_PER_BYTE - 1)) byteDoneNext = 1'b1;
          end
          if (sclFall && byteDone) begin
            byteDoneNext = 1'b0;
            bitCntNext   = '0;
            unique case (phase)
              PH_ADDR: begin
                if (rxByte[7:1] == DEV_ADDR) begin
                  stateNext       = ST_ACKOUT;
                  isReadNext      = rxByte[0];
                  firstTxNext     = 1'b1;
                  phaseNext       = PH_CMD;
                  strobe.idxClear = 1'b1;
                end else begin
                  stateNext = ST_IDLE;
                end
              end
              PH_CMD: begin
                phaseNext = PH_CNT;
                stateNext = ST_ACKOUT;
              end
              PH_CNT: begin
                phaseNext = PH_DATA;
                stateNext = ST_ACKOUT;
              end
              PH_DATA: begin
                strobe.wrCommit = 1'b1;
                stateNext       = ST_ACKOUT;
              end
              default: stateNext = ST_IDLE;
            endcase
          end
        end
        ST_ACKOUT: begin
          if (sclFall) begin
            bitCntNext = '0;
            if (isRead) begin
              stateNext         = ST_TX;
              strobe.txLoad     = 1'b1;
              strobe.txSelCount = firstTx;
              firstTxNext       = 1'b0;
            end else begin
              stateNext = ST_RX;
            end
          end
        end
        ST_TX: begin
          if (sclRise) bitCntNext = bitCnt + 1'b1;
          if (sclFall) begin
            if (bitCnt == CNT_W'(BITS_PER_BYTE)) begin
              stateNext  = ST_ACKIN;
              bitCntNext = '0;
            end else begin
              strobe.txShift = 1'b1;
            end
          end
        end
        ST_ACKIN: begin
          if (sclRise && sdaS) begin
            stateNext = ST_IDLE;
          end else if (sclFall) begin
            stateNext     = ST_TX;
            strobe.txLoad = 1'b1;
          end
        end
        default: stateNext = ST_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state    <= ST_IDLE;
      phase    <= PH_ADDR;
      bitCnt   <= '0;
      byteDone <= 1'b0;
      isRead   <= 1'b0;
      firstTx  <= 1'b0;
    end else begin
      state    <= stateNext;
      phase    <= phaseNext;
      bitCnt   <= bitCntNext;
      byteDone <= byteDoneNext;
      isRead   <= isReadNext;
      firstTx  <= firstTxNext;
    end
  end

  assign sdaDriveLow = (state == ST_ACKOUT) || ((state == ST_TX) && !txMsb);

  // a STOP always returns the control to idle
  assert_stop_idle_R10: assert property (@(posedge clk) disable iff (!rstN)
    stopDet |=> (state == ST_IDLE));

  // a new pull-low never begins while the synchronised SCL is high
  assert_drive_scl_low_R11: assert property (@(posedge clk) disable iff (!rstN)
    $rose(sdaDriveLow) |-> !sclS);

  // a START always restarts address reception from bit 0
  assert_start_addr_R10: assert property (@(posedge clk) disable iff (!rstN)
    (startDet && !stopDet) |=> (state == ST_RX && phase == PH_ADDR && bitCnt == '0));

endmodule

// File: rtl/clkctl_datapath.sv
module clkctl_datapath
  import clkctl_pkg::*;
#(
  parameter int         NUM_REGS  = 6,
  parameter logic [7:0] REG0_INIT = 8'h00,
  parameter logic [7:0] REGN_INIT = 8'hFF,
  parameter logic [7:0] FILL_BYTE = 8'hFF
) (
  input  logic                  clk,
  input  logic                  rstN,
  input  dpStrobe_t             strobe,
  input  logic                  sdaS,
  output logic [7:0]            rxByte,
  output logic                  txMsb,
  output logic [NUM_REGS*8-1:0] regBus
);

  localparam int PTR_W = $clog2(NUM_REGS + 1);
  localparam int IDX_W = (NUM_REGS > 1) ? $clog2(NUM_REGS) : 1;
  localparam logic [PTR_W-1:0] PTR_END = PTR_W'(NUM_REGS);
  localparam logic [7:0] COUNT_BYTE = 8'(NUM_REGS);

  logic [NUM_REGS-1:0][7:0] regFile;
  logic [PTR_W-1:0]         ptr;
  logic [7:0]               txByte;
  logic                     inRange;
  logic [IDX_W-1:0]         idx;
  logic [7:0]               rdValue;

  assign inRange = (ptr < PTR_END);
  assign idx     = IDX_W'(ptr);
  assign rdValue = inRange ? regFile[idx] : FILL_BYTE;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) rxByte <= '0;
    else if (strobe.rxShift) rxByte <= {rxByte[6:0], sdaS};
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      ptr <= '0;
    end else if (strobe.idxClear) begin
      ptr <= '0;
    end else if ((strobe.wrCommit || (strobe.txLoad && !strobe.txSelCount)) && inRange) begin
      ptr <= ptr + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      txByte <= 8'hFF;
    end else if (strobe.txLoad) begin
      txByte <= strobe.txSelCount ? COUNT_BYTE : rdValue;
    end else if (strobe.txShift) begin
      txByte <= {txByte[6:0], 1'b1};
    end
  end

  assign txMsb = txByte[7];

  generate
    for (genvar g = 0; g < NUM_REGS; g++) begin : g_reg
      localparam logic [7:0] INIT = (g == 0) ? REG0_INIT : REGN_INIT;
      logic hit;
      assign hit = strobe.wrCommit && inRange && (idx == IDX_W'(g));
      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN) regFile[g] <= INIT;
        else if (hit) regFile[g] <= rxByte;
      end
    end
  endgenerate

  assign regBus = regFile;

  // registers only move on a committed data byte
  assert_hold_R10: assert property (@(posedge clk) disable iff (!rstN)
    !strobe.wrCommit |=> $stable(regFile));

  // commits beyond the last register are dropped
  assert_drop_extra_R9: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.wrCommit && !inRange) |=> $stable(regFile));

  // the first data byte lands in register 0
  assert_first_reg_R3: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.wrCommit && ptr == '0) |=> (regFile[0] == $past(rxByte)));

endmodule

// File: rtl/clkctl_i2c_slave.sv
module clkctl_i2c_slave
  import clkctl_pkg::*;
#(
  parameter int         NUM_REGS    = 6,
  parameter logic [6:0] DEV_ADDR    = 7'h69,
  parameter logic [7:0] REG0_INIT   = 8'h00,
  parameter logic [7:0] REGN_INIT   = 8'hFF,
  parameter logic [7:0] FILL_BYTE   = 8'hFF,
  parameter int         SYNC_STAGES = 2
) (
  input  logic                  clk,
  input  logic                  rstN,
  input  logic                  sclIn,
  input  logic                  sdaIn,
  output logic                  sdaDriveLow,
  output logic [NUM_REGS*8-1:0] regBus
);

  logic      sclS, sdaS, sclRise, sclFall, startDet, stopDet;
  logic [7:0] rxByte;
  logic      txMsb;
  dpStrobe_t strobe;

  clkctl_busfront #(.SYNC_STAGES(SYNC_STAGES)) u_front (
    .clk(clk), .rstN(rstN), .sclIn(sclIn), .sdaIn(sdaIn),
    .sclS(sclS), .sdaS(sdaS), .sclRise(sclRise), .sclFall(sclFall),
    .startDet(startDet), .stopDet(stopDet)
  );

  clkctl_ctrl #(.DEV_ADDR(DEV_ADDR)) u_ctrl (
    .clk(clk), .rstN(rstN), .sclS(sclS), .sdaS(sdaS),
    .sclRise(sclRise), .sclFall(sclFall), .startDet(startDet), .stopDet(stopDet),
    .rxByte(rxByte), .txMsb(txMsb), .strobe(strobe), .sdaDriveLow(sdaDriveLow)
  );

  clkctl_datapath #(
    .NUM_REGS(NUM_REGS), .REG0_INIT(REG0_INIT),
    .REGN_INIT(REGN_INIT), .FILL_BYTE(FILL_BYTE)
  ) u_dp (
    .clk(clk), .rstN(rstN), .strobe(strobe), .sdaS(sdaS),
    .rxByte(rxByte), .txMsb(txMsb), .regBus(regBus)
  );

endmodule

// File: tb/clkctl_i2c_slave_tb.sv
module clkctl_i2c_slave_tb;

  localparam time CLK_PERIOD = 10ns;
  localparam int  QTR = 10;
  localparam int  NREG = 6;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic sclLine = 1'b1;
  logic mLow = 1'b0;
  logic sdaDriveLow;
  logic sdaLine;
  logic [NREG*8-1:0] regBus;
  logic [7:0] expReg [NREG];
  int checks = 0;
  int fails = 0;
  bit done = 1'b0;

  assign sdaLine = ~(mLow | sdaDriveLow);

  always #(CLK_PERIOD/2) clk = ~clk;

  clkctl_i2c_slave u_dut (
    .clk(clk), .rstN(rstN), .sclIn(sclLine), .sdaIn(sdaLine),
    .sdaDriveLow(sdaDriveLow), .regBus(regBus)
  );

  task automatic check(input string tag, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%02h expected=%02h", tag, act, exp);
    end
  endtask

  task automatic checkRegs(input string tag);
    for (int i = 0; i < NREG; i++) check(tag, regBus[8*i +: 8], expReg[i]);
  endtask

  task automatic waitQ();
    repeat (QTR) @(negedge clk);
  endtask

  task automatic busStart();
    if (!sclLine) begin
      mLow = 1'b0; waitQ();
      sclLine = 1'b1; waitQ();
    end
    mLow = 1'b1; waitQ(); waitQ();
    sclLine = 1'b0; waitQ();
  endtask

  task automatic busStop();
    mLow = 1'b1; waitQ();
    sclLine = 1'b1; waitQ();
    mLow = 1'b0; waitQ(); waitQ();
  endtask

  task automatic putBit(input logic b);
    mLow = ~b; waitQ();
    sclLine = 1'b1; waitQ(); waitQ();
    sclLine = 1'b0; waitQ();
  endtask

  task automatic getBit(output logic b);
    mLow = 1'b0; waitQ();
    sclLine = 1'b1; waitQ();
    b = sdaLine; waitQ();
    sclLine = 1'b0; waitQ();
  endtask

  task automatic sendByte(input logic [7:0] v, output logic acked);
    logic b;
    for (int i = 7; i >= 0; i--) putBit(v[i]);
    getBit(b);
    acked = ~b;
  endtask

  task automatic recvByte(input logic ack, output logic [7:0] v);
    logic b;
    for (int i = 7; i >= 0; i--) begin
      getBit(b);
      v[i] = b;
    end
    putBit(~ack);
    mLow = 1'b0;
  endtask

  task automatic testReset();
    for (int i = 0; i < NREG; i++) expReg[i] = (i == 0) ? 8'h00 : 8'hFF;
    checkRegs("R6 reset values");
    check("R11 released at reset", {7'd0, sdaDriveLow}, 8'h00);
  endtask

  task automatic testWrongAddr();
    logic a;
    busStart();
    sendByte(8'hA0, a);
    check("R1 foreign address not acked", {7'd0, a}, 8'h00);
    sendByte(8'h00, a);
    sendByte(8'h00, a);
    sendByte(8'h5A, a);
    check("R1 bus ignored after foreign address", {7'd0, a}, 8'h00);
    busStop();
    checkRegs("R1 regs untouched");
  endtask

  task automatic testNoStartOnLowEdges();
    logic a;
    sclLine = 1'b0; waitQ();
    mLow = 1'b1; waitQ();
    mLow = 1'b0; waitQ();
    mLow = 1'b1; waitQ();
    sendByte(8'hD2, a);
    check("R12 SDA edges with SCL low give no START", {7'd0, a}, 8'h00);
    busStop();
    checkRegs("R12 regs untouched");
  endtask

  task automatic testShortWrite();
    logic a;
    logic allAck = 1'b1;
    busStart();
    sendByte(8'hD2, a); check("R1 write address acked", {7'd0, a}, 8'h01);
    sendByte(8'h03, a); allAck &= a;
    sendByte(8'h07, a); allAck &= a;
    check("R2 header bytes acked", {7'd0, allAck}, 8'h01);
    sendByte(8'hC1, a); allAck &= a;
    sendByte(8'hC2, a); allAck &= a;
    sendByte(8'hC3, a); allAck &= a;
    busStop();
    check("R7 all bytes acked", {7'd0, allAck}, 8'h01);
    expReg[0] = 8'hC1; expReg[1] = 8'hC2; expReg[2] = 8'hC3;
    checkRegs("R3 R4 R2 upward from register 0");
  endtask

  task automatic testLongWrite();
    logic a;
    logic allAck = 1'b1;
    busStart();
    sendByte(8'hD2, a); allAck &= a;
    sendByte(8'h00, a); allAck &= a;
    sendByte(8'h06, a); allAck &= a;
    for (int i = 0; i < NREG + 2; i++) begin
      sendByte(8'(8'h11 * (i + 1)), a);
      allAck &= a;
    end
    busStop();
    check("R7 R9 bytes past last register acked", {7'd0, allAck}, 8'h01);
    for (int i = 0; i < NREG; i++) expReg[i] = 8'(8'h11 * (i + 1));
    checkRegs("R9 R3 extra write bytes dropped");
  endtask

  task automatic testRead();
    logic a;
    logic [7:0] v;
    busStart();
    sendByte(8'hD3, a); check("R1 read address acked", {7'd0, a}, 8'h01);
    recvByte(1'b1, v); check("R8 R5 byte count first", v, 8'd6);
    for (int i = 0; i < NREG; i++) begin
      recvByte(1'b1, v);
      check("R5 register read-back", v, expReg[i]);
    end
    recvByte(1'b1, v); check("R9 fill past last register", v, 8'hFF);
    recvByte(1'b0, v); check("R9 fill second extra", v, 8'hFF);
    check("R11 released after master NACK", {7'd0, sdaDriveLow}, 8'h00);
    busStop();
    checkRegs("R5 read leaves registers");
  endtask

  task automatic testPartialWrite();
    logic a;
    busStart();
    sendByte(8'hD2, a);
    sendByte(8'hFF, a);
    sendByte(8'hFF, a);
    sendByte(8'hA0, a);
    sendByte(8'hA1, a);
    busStop();
    expReg[0] = 8'hA0; expReg[1] = 8'hA1;
    checkRegs("R4 stop after second data byte");
  endtask

  task automatic testAbort();
    logic a;
    logic [7:0] v;
    busStart();
    sendByte(8'hD2, a);
    sendByte(8'h00, a);
    sendByte(8'h00, a);
    putBit(1'b0); putBit(1'b1); putBit(1'b0); putBit(1'b1);
    busStop();
    checkRegs("R10 stop mid-byte changes nothing");
    busStart();
    sendByte(8'hD2, a);
    sendByte(8'h00, a);
    sendByte(8'h00, a);
    putBit(1'b0); putBit(1'b0); putBit(1'b1);
    busStart();
    checkRegs("R10 repeated start mid-byte changes nothing");
    sendByte(8'hD3, a); check("R10 address decoded after repeated start", {7'd0, a}, 8'h01);
    recvByte(1'b1, v); check("R10 R8 count after repeated start", v, 8'd6);
    recvByte(1'b0, v); check("R10 register 0 after repeated start", v, expReg[0]);
    busStop();
  endtask

  initial begin
    repeat (5) @(negedge clk);
    rstN = 1'b1;
    repeat (5) @(negedge clk);
    testReset();
    testWrongAddr();
    testNoStartOnLowEdges();
    testShortWrite();
    testLongWrite();
    testRead();
    testPartialWrite();
    testAbort();
    done = 1'b1;
  end

  initial begin
    fork
      begin
        wait (done);
      end
      begin
        repeat (150000) @(posedge clk);
        checks++;
        fails++;
        $display("FAIL watchdog expired actual=running expected=finished");
      end
    join_any
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

endmodule